// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the sequence of 23-bit word addresses for one synchronous burst access to a 16-bit-wide pseudo-static memory. A load strobe supplies a start address, a length code and a wrap/linear choice. The block then presents one address per beat on a valid/ready output. The consumer takes a beat by holding `beat_ready_i` high while `beat_valid_o` is high. When ready is low, the current address is held and re-presented. This is the only back-pressure path. There is no input handshake: a load is always accepted at once.

Fixed bursts are 4, 8, 16 or 32 words long. In wrap mode the address cycles inside the aligned block whose size equals the burst length. In linear mode the address counts up by one and may leave that block. A length code of 4 or higher selects a continuous burst. A continuous burst ignores the wrap choice and counts up until a new load replaces it.

A burst that is not wrapping can move onto a new 128-word row. The block then raises `row_stall_o` and withholds the beat until the row logic pulses `row_ack_i`. The block only signals the stall; it does not time it.

Top module: `burst_seq_gen`

## Requirements
- R1: After reset, `beat_valid_o`, `beat_last_o` and `row_stall_o` are low and `addr_o` is zero.
- R2: A cycle with `load_i` high starts a burst: on the next cycle `beat_valid_o` is high and `addr_o` equals the loaded start address.
- R3: With `wrap_i` high and length code 0, 1, 2 or 3 (4, 8, 16, 32 words), each accepted beat increments only the low code+2 address bits modulo the burst length and leaves the upper bits unchanged. Example: length 8 starting at offset 1 gives 1,2,3,4,5,6,7,0.
- R4: With `wrap_i` low and a fixed length, each accepted beat adds one to the full address. The sequence crosses block boundaries (length 8 from offset 1 gives 1 through 8).
- R5: A fixed burst of N words delivers exactly N beats. `beat_last_o` is high on the Nth beat only. After that beat is accepted, `beat_valid_o` is low until the next load.
- R6: Length codes 4 to 7 select continuous mode. It ignores `wrap_i`, adds one per accepted beat, and never raises `beat_last_o`.
- R7: The address changes only on a clock edge where `beat_valid_o` and `beat_ready_i` are both high, or where a load occurs. `beat_valid_o` is low while `row_stall_o` is high.
- R8: A non-wrapping burst that advances to an address whose low 7 bits are zero raises `row_stall_o` on that cycle. The stall holds the address until a cycle with `row_ack_i` high, after which the beat becomes valid. A wrapping burst never raises the stall.
- R9: A load during an active burst aborts it, clears any pending stall, and restarts from the new start address with the new length and mode.
- R10: A linear or continuous burst past address 7FFFFFh continues at address 0. This is a row crossing (R8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Start a new burst with the values below |
| start_addr_i | input | 23 | Word address of the first beat |
| len_code_i | input | 3 | 0:4, 1:8, 2:16, 3:32 words, 4-7: continuous |
| wrap_i | input | 1 | 1 = wrap inside the aligned block, 0 = linear |
| beat_ready_i | input | 1 | Consumer takes the presented beat |
| row_ack_i | input | 1 | Row logic releases a pending stall |
| beat_valid_o | output | 1 | A beat address is presented |
| addr_o | output | 23 | Current word address |
| beat_last_o | output | 1 | Presented beat is the final one of a fixed burst |
| row_stall_o | output | 1 | Row-crossing stall pending |

## Verification
Assertions placed in the RTL check the following on every cycle:
- a load shows its start address one cycle later;
- an idle or back-pressured cycle leaves the address unchanged;
- a linear step adds exactly one;
- a wrapping step keeps the upper address bits;
- the beat counter never decrements past zero;
- the stall rises only on a row-aligned address and never in wrap mode.

Only the bench's scenarios can show the following:
- the full beat ordering for each length and mode;
- that exactly N beats are delivered with `beat_last_o` on the final one;
- that a held stall keeps the address until acknowledged;
- that an abort takes the new parameters;
- that continuous bursts pass the top address without ever signalling a last beat.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [1:0] {
    MODE_LINEAR = 2'd0,
    MODE_WRAP   = 2'd1,
    MODE_STREAM = 2'd2
  } burst_mode_e;

  function automatic logic code_is_stream(input int unsigned code, input int unsigned n_fixed);
    return code >= n_fixed;
  endfunction

endpackage

// File: rtl/burst_addr_step.sv
module burst_addr_step #(
  parameter int ADDR_W  = 23,
  parameter int ROW_W   = 7,
  parameter int CODE_W  = 3,
  parameter int MIN_LOG = 2,
  parameter int MAX_LOG = 5
) (
  input  logic [ADDR_W-1:0] cur_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              wrap_i,
  output logic [ADDR_W-1:0] next_o,
  output logic              row_cross_o
);
  logic [ADDR_W-1:0] inc;
  logic [ADDR_W-1:0] blk_mask;

  assign inc = cur_i + ADDR_W'(1);

  // Bits that belong to the wrapping block for the selected length.
  for (genvar b = 0; b < ADDR_W; b++) begin : g_mask
    if (b < MIN_LOG) begin : g_always
      assign blk_mask[b] = 1'b1;
    end else if (b < MAX_LOG) begin : g_coded
      assign blk_mask[b] = (code_i > CODE_W'(b - MIN_LOG));
    end else begin : g_never
      assign blk_mask[b] = 1'b0;
    end
  end

  assign next_o      = wrap_i ? ((cur_i & ~blk_mask) | (inc & blk_mask)) : inc;
  assign row_cross_o = !wrap_i && (next_o[ROW_W-1:0] == '0);
endmodule

// File: rtl/burst_beat_count.sv
module burst_beat_count #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] init_i,
  input  logic             dec_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      left_q <= '0;
    else if (load_i) left_q <= init_i;
    else if (dec_i)  left_q <= left_q - CNT_W'(1);
  end

  assign zero_o = (left_q == '0);

  // R5: a step is never requested once the final beat has been reached
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !load_i) |-> !zero_o);
endmodule

// File: rtl/burst_row_hold.sv
module burst_row_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic set_i,
  input  logic clr_i,
  output logic stall_o
);
  logic stall_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stall_q <= 1'b0;
    else if (load_i) stall_q <= 1'b0;
    else if (set_i)  stall_q <= 1'b1;
    else if (clr_i)  stall_q <= 1'b0;
  end

  assign stall_o = stall_q;

  // R8: a new crossing is only raised while no stall is pending
  assert_single_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |-> !stall_o);
endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W  = 23,
  parameter int ROW_W   = 7,
  parameter int CODE_W  = 3,
  parameter int N_FIXED = 4,
  parameter int MIN_LOG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CODE_W-1:0] len_code_i,
  input  logic              wrap_i,
  input  logic              beat_ready_i,
  input  logic              row_ack_i,
  output logic              beat_valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              beat_last_o,
  output logic              row_stall_o
);
  localparam int MAX_LOG = MIN_LOG + N_FIXED - 1;
  localparam int CNT_W   = MAX_LOG;

  logic              act_q;
  logic [ADDR_W-1:0] addr_q;
  burst_mode_e       mode_q;
  logic [CODE_W-1:0] code_q;

  logic [ADDR_W-1:0] nxt_addr;
  logic              row_cross, cnt_zero, stall;
  logic              fire, is_last, step;
  burst_mode_e       new_mode;
  logic [CNT_W-1:0]  cnt_init;

  assign fire    = act_q && !stall && beat_ready_i;
  assign is_last = act_q && (mode_q != MODE_STREAM) && cnt_zero;
  assign step    = fire && !is_last && !load_i;

  always_comb begin
    if (code_is_stream(32'(len_code_i), N_FIXED)) begin
      new_mode = MODE_STREAM;
      cnt_init = '0;
    end else begin
      new_mode = wrap_i ? MODE_WRAP : MODE_LINEAR;
      cnt_init = CNT_W'((32'd1 << (32'(len_code_i) + MIN_LOG)) - 32'd1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      addr_q <= '0;
      mode_q <= MODE_LINEAR;
      code_q <= '0;
    end else if (load_i) begin
      act_q  <= 1'b1;
      addr_q <= start_addr_i;
      mode_q <= new_mode;
      code_q <= len_code_i;
    end else if (fire) begin
      if (is_last) act_q  <= 1'b0;
      else         addr_q <= nxt_addr;
    end
  end

  burst_addr_step #(
    .ADDR_W (ADDR_W),
    .ROW_W  (ROW_W),
    .CODE_W (CODE_W),
    .MIN_LOG(MIN_LOG),
    .MAX_LOG(MAX_LOG)
  ) step_i (
    .cur_i      (addr_q),
    .code_i     (code_q),
    .wrap_i     (mode_q == MODE_WRAP),
    .next_o     (nxt_addr),
    .row_cross_o(row_cross)
  );

  burst_beat_count #(.CNT_W(CNT_W)) count_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(load_i),
    .init_i(cnt_init),
    .dec_i (step && (mode_q != MODE_STREAM)),
    .zero_o(cnt_zero)
  );

  burst_row_hold hold_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_i),
    .set_i  (step && row_cross),
    .clr_i  (row_ack_i),
    .stall_o(stall)
  );

  assign beat_valid_o = act_q && !stall;
  assign addr_o       = addr_q;
  assign beat_last_o  = is_last;
  assign row_stall_o  = stall;

  // R2: a load presents its start address on the next cycle
  assert_load_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (beat_valid_o && addr_o == $past(start_addr_i)));

  // R7: no accepted beat and no load leaves the address in place
  assert_hold_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !(beat_valid_o && beat_ready_i)) |=> (addr_o == $past(addr_o)));

  // R4: a linear step moves the address up by exactly one
  assert_linear_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode_q == MODE_LINEAR) |=> (addr_o == ADDR_W'($past(addr_o) + ADDR_W'(1))));

  // R3: a wrapping step keeps every bit above the largest block
  assert_wrap_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode_q == MODE_WRAP) |=>
      (addr_o[ADDR_W-1:MAX_LOG] == $past(addr_o[ADDR_W-1:MAX_LOG])));

  // R5: accepting the last beat ends the burst
  assert_end_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && beat_ready_i && beat_last_o && !load_i) |=> !beat_valid_o);

  // R8: the stall appears only on a row-aligned address
  assert_stall_on_row_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(row_stall_o) |-> (addr_o[ROW_W-1:0] == '0));

  // R8: wrapping bursts never stall
  assert_wrap_nostall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && mode_q == MODE_WRAP) |-> !row_stall_o);
endmodule

// File: tb/burst_seq_gen_tb.sv
`timescale 1ns/1ps
module burst_seq_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_i = 1'b0;
  logic [22:0] start_addr_i = '0;
  logic [2:0]  len_code_i = '0;
  logic        wrap_i = 1'b0;
  logic        beat_ready_i = 1'b0;
  logic        row_ack_i = 1'b0;
  logic        beat_valid_o, beat_last_o, row_stall_o;
  logic [22:0] addr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  burst_seq_gen dut_i (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_addr_i(start_addr_i),
    .len_code_i(len_code_i), .wrap_i(wrap_i), .beat_ready_i(beat_ready_i),
    .row_ack_i(row_ack_i), .beat_valid_o(beat_valid_o), .addr_o(addr_o),
    .beat_last_o(beat_last_o), .row_stall_o(row_stall_o)
  );

  // Reference model state
  bit          m_act = 0, m_cont = 0, m_wrap = 0, m_stall = 0;
  logic [22:0] m_addr = '0;
  int          m_left = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [22:0] exp_addr(input logic [22:0] s, input int code, input bit wr, input int i);
    logic [22:0] m;
    if (code < 4 && wr) begin
      m = 23'((1 << (code + 2)) - 1);
      return (s & ~m) | (23'(s + 23'(i)) & m);
    end
    return 23'(s + 23'(i));
  endfunction

  task automatic model_step();
    logic [22:0] nx;
    bit v;
    if (load_i) begin
      m_act = 1; m_addr = start_addr_i; m_cont = (len_code_i >= 3'd4);
      m_wrap = wrap_i && !m_cont; m_stall = 0;
      m_left = m_cont ? 0 : (4 << len_code_i) - 1;
    end else begin
      v = m_act && !m_stall;
      if (v && beat_ready_i) begin
        if (!m_cont && m_left == 0) m_act = 0;
        else begin
          nx = m_wrap ? exp_addr(m_addr, 0, 0, 1) : 23'(m_addr + 23'd1);
          if (m_wrap) begin
            case (m_left) default: ; endcase
          end
          m_addr = nx;
          if (!m_cont) m_left--;
          if (!m_wrap && nx[6:0] == 7'd0) m_stall = 1;
        end
      end else if (m_stall && row_ack_i) m_stall = 0;
    end
  endtask

  // Wrapping needs the block size, kept separately from the shared step above.
  int m_code = 0;
  task automatic model_cycle();
    logic [22:0] base;
    logic [22:0] old;
    bit was_wrap_step;
    old = m_addr;
    was_wrap_step = !load_i && m_wrap && m_act && !m_stall && beat_ready_i && m_left != 0;
    if (load_i) m_code = int'(len_code_i);
    model_step();
    if (was_wrap_step) begin
      base = exp_addr(old, m_code, 1, 1);
      m_addr = base;
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_cycle();
    @(negedge clk);
    check("R7 valid", 32'(beat_valid_o), 32'(m_act && !m_stall));
    check(m_wrap ? "R3 addr" : (m_cont ? "R6 addr" : "R4 addr"), 32'(addr_o), 32'(m_addr));
    check("R5 last", 32'(beat_last_o), 32'(m_act && !m_cont && m_left == 0));
    check("R8 stall", 32'(row_stall_o), 32'(m_stall));
  endtask

  task automatic run_burst(input logic [22:0] s, input int code, input bit wr, input int take,
                           input bit end_chk, input string tag);
    int i = 0;
    int guard = 0;
    load_i = 1; start_addr_i = s; len_code_i = 3'(code); wrap_i = wr;
    beat_ready_i = 1; row_ack_i = 1;
    cyc();
    load_i = 0;
    while (i < take && guard < 300) begin
      if (beat_valid_o) begin
        check(tag, 32'(addr_o), 32'(exp_addr(s, code, wr, i)));
        if (code < 4) check("R5 last flag", 32'(beat_last_o), 32'(i == (4 << code) - 1));
        else          check("R6 no last", 32'(beat_last_o), 32'd0);
        if (wr && code < 4) check("R8 wrap no stall", 32'(row_stall_o), 32'd0);
        i++;
      end
      if (i < take) cyc();
      guard++;
    end
    check("R5 beat count", 32'(i), 32'(take));
    if (end_chk) begin
      cyc();
      check("R5 ends", 32'(beat_valid_o), 32'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R7 actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 valid", 32'(beat_valid_o), 32'd0);
    check("R1 last", 32'(beat_last_o), 32'd0);
    check("R1 stall", 32'(row_stall_o), 32'd0);
    check("R1 addr", 32'(addr_o), 32'd0);

    // R2 / R3: wrap 8 from offset 1 -> 1..7,0
    run_burst(23'h000401, 1, 1, 8, 1, "R3 wrap8");
    run_burst(23'h12345D, 0, 1, 4, 1, "R3 wrap4");
    run_burst(23'h0000F3, 3, 1, 32, 1, "R3 wrap32");
    // R4: linear 8 from offset 1 -> 1..8
    run_burst(23'h000201, 1, 0, 8, 1, "R4 linear8");
    run_burst(23'h00027C, 2, 0, 16, 1, "R4 linear16 row");
    // R6: continuous ignores wrap
    run_burst(23'h000030, 7, 1, 40, 0, "R6 cont");
    // R9: abort partway, restart elsewhere
    run_burst(23'h000500, 3, 0, 3, 0, "R4 before abort");
    run_burst(23'h0007A6, 1, 1, 8, 1, "R9 restart");
    // R10: top of address space
    run_burst(23'h7FFFF8, 4, 0, 20, 0, "R10 top wrap");
    run_burst(23'h7FFFFE, 0, 0, 4, 1, "R10 top linear");

    // R8: held stall
    load_i = 1; start_addr_i = 23'h00007E; len_code_i = 3'd0; wrap_i = 0;
    beat_ready_i = 1; row_ack_i = 0;
    cyc(); load_i = 0;
    cyc(); cyc();
    for (int k = 0; k < 4; k++) begin
      check("R8 stall held", 32'(row_stall_o), 32'd1);
      check("R8 no beat", 32'(beat_valid_o), 32'd0);
      check("R8 addr held", 32'(addr_o), 32'h80);
      cyc();
    end
    row_ack_i = 1;
    cyc();
    check("R8 released", 32'(beat_valid_o), 32'd1);
    check("R8 addr", 32'(addr_o), 32'h80);
    cyc();
    check("R5 last after stall", 32'(beat_last_o), 32'd1);
    check("R4 addr", 32'(addr_o), 32'h81);

    // R7: advance low holds the address
    load_i = 1; start_addr_i = 23'h000100; len_code_i = 3'd1; wrap_i = 0;
    beat_ready_i = 0;
    cyc(); load_i = 0;
    for (int k = 0; k < 4; k++) begin
      check("R7 hold", 32'(addr_o), 32'h100);
      cyc();
    end
    beat_ready_i = 1;
    cyc();
    check("R7 advance", 32'(addr_o), 32'h101);

    // Random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      load_i = ($urandom_range(15) == 0);
      start_addr_i = ($urandom_range(1) == 1) ? {16'($urandom), 7'h70 | 7'($urandom_range(15))}
                                              : 23'($urandom);
      len_code_i = 3'($urandom_range(7));
      wrap_i = 1'($urandom_range(1));
      beat_ready_i = ($urandom_range(3) != 0);
      row_ack_i = ($urandom_range(2) == 0);
      cyc();
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule